// File: doc/BRIEF.md
# Shared-Cache Line Eviction and Probe Responder

This block owns the coherence bookkeeping of one shared-cache line while that line is being evicted or probed by the directory. A fill port installs a stable state (modified, owned, exclusive, shared or invalid) together with the line data and its dirty bit. A replacement request turns a valid line into a victim message, either dirty or clean, sent on a valid/ready channel. The data is parked in a holding buffer, the line is invalidated, and the block waits for memory to acknowledge the writeback.

Probes arrive on a valid/ready channel. Each one carries a 2-bit kind and a return-data bit, and each one produces exactly one response. The response carries hit, dirty and not-shared-locally flags and, where applicable, the data. A probe that lands while an eviction is in flight is answered from the holding buffer. An invalidating probe in that window moves the line into a cancel-wait state. That state blocks victim notices from lower caches until memory acknowledges. A victim notice that races with the eviction is acknowledged, and the late writeback data that follows is dropped through two dedicated states.

The probe response channel has one register stage. A new probe is accepted (`prb_ready` high) when the response register is empty or is being drained in the same cycle. A pending response and a pending victim message each hold all of their fields stable until the consumer raises its ready. Victim notices use `vn_valid`/`vn_ready`. Memory acknowledge, late data, replacement and fill are single-cycle pulses.

Top module: `lc_evict_ctrl`

## Requirements
- R1: After reset `line_st` is 0 (invalid), and `rsp_valid`, `vic_valid`, `err`, `vn_ack` and `unblk_inval` are all 0. State codes on `line_st`: 0 invalid, 1 shared, 2 exclusive, 3 owned, 4 modified, 5 evicting-dirty, 6 evicting-clean, 7 evicting-with-racing-victim, 8 drop-late-data, 9 cancel-wait.
- R2: A `fill_en` pulse installs `fill_st`, `fill_data` and `fill_dirty`. It takes effect only while `line_st` is 0 to 4 and `fill_st` is 0 to 4; otherwise it is ignored.
- R3: A `repl_req` pulse in state 3 or 4 raises `vic_valid` with `vic_is_dirty`=1 and `vic_data` set to the line data, and moves the line to state 5. In state 1 or 2 it raises `vic_valid` with `vic_is_dirty`=0 and moves the line to state 6. In both cases the data and dirty bit are copied to the holding buffer. In any other state, or while `vic_valid` is high, the pulse is ignored. The victim message holds its fields until `vic_ready`.
- R4: Probe kind encoding: `prb_kind`=00 is invalidate, 01 is downgrade, 10 and 11 are reserved. An invalidate with `prb_ret`=1 on states 1 to 4 returns the line data and its dirty bit with hit=1 and has_data=1, and the line goes to state 0. On states 0, 7 and 8 it returns hit=0, nsl=1 and no data, and the state is unchanged.
- R5: An invalidate with `prb_ret`=0 in states 1 to 4 returns hit=0, nsl=1 and no data, and the line goes to state 0.
- R6: A downgrade with `prb_ret`=1 returns the line data and dirty bit with hit=1. States 3 and 4 go to 3, and states 1 and 2 go to 1. In states 0, 7, 8 and 9 it returns a miss (hit=0, nsl=0, no data) and the state is unchanged.
- R7: In state 5, an invalidate with data returns the held data and held dirty bit with hit=1. In state 6 it returns hit=0, nsl=1 and no data. Either way the line goes to state 9. An invalidate without data in states 5 or 6 returns nsl=1 and goes to 9. A downgrade in states 5 or 6 returns the held data with hit=1, and the state is unchanged.
- R8: A `mem_ack` pulse in states 5, 6 or 9 frees the holding buffer and goes to state 0. In state 7 it goes to state 8.
- R9: An accepted victim notice in state 5 pulses `vn_ack` and moves to state 7. A `wbd_valid` pulse in state 7 pulses `unblk_inval` and returns to 5. In state 8 it pulses `unblk_inval` and goes to 0. In other states neither pulse changes state.
- R10: In state 9, `vn_ready` is 0 so victim notices are held off, and an invalidate probe returns nsl=1 with no data.
- R11: A downgrade with `prb_ret`=0, or a reserved kind, pulses `err` for one cycle, returns a miss response, and leaves the state unchanged.
- R12: Every accepted probe (`prb_valid` and `prb_ready`) yields exactly one response one cycle later. `prb_ready` = !`rsp_valid` or `rsp_ready`. A pending response holds its fields until `rsp_ready`.
- R13: Events in the same cycle are taken in this order: accepted probe, `mem_ack`, `wbd_valid`, victim notice, `repl_req`, `fill_en`. Only the first one present takes effect, and `vn_ready` is 0 whenever a higher-priority event is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Install a stable state |
| fill_st | input | 4 | State code to install |
| fill_data | input | DW | Line data to install |
| fill_dirty | input | 1 | Dirty bit to install |
| repl_req | input | 1 | Replacement request pulse |
| prb_valid | input | 1 | Probe valid |
| prb_ready | output | 1 | Probe ready |
| prb_kind | input | 2 | Probe kind |
| prb_ret | input | 1 | Probe asks for data |
| rsp_valid | output | 1 | Probe response valid |
| rsp_ready | input | 1 | Probe response ready |
| rsp_hit | output | 1 | Response hit flag |
| rsp_dirty | output | 1 | Response dirty flag |
| rsp_nsl | output | 1 | Response not-shared-locally flag |
| rsp_has_data | output | 1 | Response carries data |
| rsp_data | output | DW | Response data |
| vic_valid | output | 1 | Victim message valid |
| vic_ready | input | 1 | Victim message ready |
| vic_is_dirty | output | 1 | Victim is the dirty kind |
| vic_data | output | DW | Victim data |
| mem_ack | input | 1 | Memory writeback acknowledge |
| vn_valid | input | 1 | Victim notice from a lower cache |
| vn_ready | output | 1 | Victim notice accepted |
| vn_ack | output | 1 | Victim notice acknowledge pulse |
| wbd_valid | input | 1 | Late writeback data pulse |
| unblk_inval | output | 1 | Unblock-not-valid pulse |
| err | output | 1 | Malformed probe pulse |
| line_st | output | 4 | Current line state code |

## Verification
Assertions check the handshake rules on every cycle: a response follows each accepted probe, and pending responses and victims stay stable under back-pressure. They also check that memory acknowledge in an eviction state returns the line to invalid, that victim notices are blocked in cancel-wait, that a malformed probe leaves the state alone, and that the holding buffer is never loaded twice. The data and flag contents of each response, the dirty/clean choice of a victim, and the racing-notice path through the drop-late-data states are exposed only by the bench. It compares those against its reference model, both in directed sequences (including a probe colliding with a memory acknowledge) and in a long random mix.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [3:0] {
    LS_I    = 4'd0,
    LS_S    = 4'd1,
    LS_E    = 4'd2,
    LS_O    = 4'd3,
    LS_M    = 4'd4,
    LS_MOI  = 4'd5,
    LS_ESI  = 4'd6,
    LS_MODI = 4'd7,
    LS_DI   = 4'd8,
    LS_IC   = 4'd9
  } line_st_e;

  typedef enum logic [1:0] {
    PO_NONE     = 2'd0,
    PO_INV_DATA = 2'd1,
    PO_INV      = 2'd2,
    PO_DOWN     = 2'd3
  } probe_op_e;

  localparam logic [1:0] KIND_INV  = 2'b00;
  localparam logic [1:0] KIND_DOWN = 2'b01;
endpackage

// File: rtl/lc_probe_decode.sv
module lc_probe_decode
  import lc_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       ret,
  output probe_op_e  op,
  output logic       bad
);
  always_comb begin
    op  = PO_NONE;
    bad = 1'b0;
    unique case (kind)
      KIND_INV:  op = ret ? PO_INV_DATA : PO_INV;
      KIND_DOWN: begin
        if (ret) op = PO_DOWN;
        else     bad = 1'b1;
      end
      default:   bad = 1'b1;
    endcase
  end

  // R11: a malformed probe never decodes to an operation
  always_comb begin
    a_r11_bad_no_op: assert (!(bad && (op != PO_NONE)));
  end
endmodule

// File: rtl/lc_probe_resp.sv
module lc_probe_resp
  import lc_pkg::*;
(
  input  line_st_e  st,
  input  probe_op_e op,
  output logic      hit,
  output logic      nsl,
  output logic      use_line,
  output logic      use_hold,
  output line_st_e  nxt
);
  logic inv_any;
  assign inv_any = (op == PO_INV_DATA) || (op == PO_INV);

  always_comb begin
    hit      = 1'b0;
    nsl      = 1'b0;
    use_line = 1'b0;
    use_hold = 1'b0;
    nxt      = st;
    unique case (st)
      LS_S, LS_E, LS_O, LS_M: begin
        if (op == PO_INV_DATA) begin
          hit = 1'b1; use_line = 1'b1; nxt = LS_I;
        end else if (op == PO_INV) begin
          nsl = 1'b1; nxt = LS_I;
        end else if (op == PO_DOWN) begin
          hit = 1'b1; use_line = 1'b1;
          nxt = ((st == LS_O) || (st == LS_M)) ? LS_O : LS_S;
        end
      end
      LS_MOI: begin
        if (op == PO_INV_DATA) begin
          hit = 1'b1; use_hold = 1'b1; nxt = LS_IC;
        end else if (op == PO_INV) begin
          nsl = 1'b1; nxt = LS_IC;
        end else if (op == PO_DOWN) begin
          hit = 1'b1; use_hold = 1'b1;
        end
      end
      LS_ESI: begin
        if (inv_any) begin
          nsl = 1'b1; nxt = LS_IC;
        end else if (op == PO_DOWN) begin
          hit = 1'b1; use_hold = 1'b1;
        end
      end
      default: begin
        if (inv_any) nsl = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lc_hold_buf.sv
module lc_hold_buf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_dirty,
  output logic [DW-1:0] data,
  output logic          dirty,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      dirty <= 1'b0;
      full  <= 1'b0;
    end else if (load) begin
      data  <= ld_data;
      dirty <= ld_dirty;
      full  <= 1'b1;
    end else if (clear) begin
      data  <= '0;
      dirty <= 1'b0;
      full  <= 1'b0;
    end
  end

  // R3: the buffer is only captured when it is free
  a_r3_no_double_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full);
endmodule

// File: rtl/lc_evict_ctrl.sv
module lc_evict_ctrl
  import lc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [3:0]    fill_st,
  input  logic [DW-1:0] fill_data,
  input  logic          fill_dirty,
  input  logic          repl_req,
  input  logic          prb_valid,
  output logic          prb_ready,
  input  logic [1:0]    prb_kind,
  input  logic          prb_ret,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_hit,
  output logic          rsp_dirty,
  output logic          rsp_nsl,
  output logic          rsp_has_data,
  output logic [DW-1:0] rsp_data,
  output logic          vic_valid,
  input  logic          vic_ready,
  output logic          vic_is_dirty,
  output logic [DW-1:0] vic_data,
  input  logic          mem_ack,
  input  logic          vn_valid,
  output logic          vn_ready,
  output logic          vn_ack,
  input  logic          wbd_valid,
  output logic          unblk_inval,
  output logic          err,
  output logic [3:0]    line_st
);
  line_st_e      st;
  logic [DW-1:0] line_data;
  logic          line_dirty;

  probe_op_e     op;
  logic          dec_bad;
  logic          p_hit, p_nsl, p_use_line, p_use_hold;
  line_st_e      p_nxt;

  logic [DW-1:0] hold_data;
  logic          hold_dirty, hold_full;
  logic          hold_load, hold_clear;

  logic prb_fire, vn_fire, repl_go, fill_go, st_stable, st_owned;
  logic ack_frees;

  lc_probe_decode u_dec (
    .kind(prb_kind), .ret(prb_ret), .op(op), .bad(dec_bad)
  );

  lc_probe_resp u_resp (
    .st(st), .op(op), .hit(p_hit), .nsl(p_nsl),
    .use_line(p_use_line), .use_hold(p_use_hold), .nxt(p_nxt)
  );

  lc_hold_buf #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .clear(hold_clear),
    .ld_data(line_data), .ld_dirty(line_dirty),
    .data(hold_data), .dirty(hold_dirty), .full(hold_full)
  );

  assign line_st   = st;
  assign st_stable = (st <= LS_M);
  assign st_owned  = (st == LS_O) || (st == LS_M);
  assign prb_ready = !rsp_valid || rsp_ready;
  assign prb_fire  = prb_valid && prb_ready;
  assign ack_frees = (st == LS_MOI) || (st == LS_ESI) || (st == LS_IC);
  assign vn_ready  = (st != LS_IC) && !prb_fire && !mem_ack && !wbd_valid;
  assign vn_fire   = vn_valid && vn_ready;
  assign repl_go   = repl_req && !vic_valid && (st >= LS_S) && st_stable &&
                     !prb_fire && !mem_ack && !wbd_valid && !vn_fire;
  assign fill_go   = fill_en && st_stable && (fill_st <= 4'(LS_M)) &&
                     !prb_fire && !mem_ack && !wbd_valid && !vn_fire && !repl_go;
  assign hold_load  = repl_go;
  assign hold_clear = !prb_fire && mem_ack && (ack_frees || (st == LS_MODI));

  // Probe response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_dirty    <= 1'b0;
      rsp_nsl      <= 1'b0;
      rsp_has_data <= 1'b0;
      rsp_data     <= '0;
      err          <= 1'b0;
    end else begin
      err <= prb_fire && dec_bad;
      if (prb_fire) begin
        rsp_valid    <= 1'b1;
        rsp_hit      <= p_hit;
        rsp_nsl      <= p_nsl;
        rsp_has_data <= p_use_line || p_use_hold;
        rsp_dirty    <= p_use_line ? line_dirty : (p_use_hold ? hold_dirty : 1'b0);
        rsp_data     <= p_use_line ? line_data  : (p_use_hold ? hold_data  : '0);
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // Victim message register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid    <= 1'b0;
      vic_is_dirty <= 1'b0;
      vic_data     <= '0;
    end else if (repl_go) begin
      vic_valid    <= 1'b1;
      vic_is_dirty <= st_owned;
      vic_data     <= line_data;
    end else if (vic_ready) begin
      vic_valid <= 1'b0;
    end
  end

  // Line state sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= LS_I;
      line_data   <= '0;
      line_dirty  <= 1'b0;
      vn_ack      <= 1'b0;
      unblk_inval <= 1'b0;
    end else begin
      vn_ack      <= 1'b0;
      unblk_inval <= 1'b0;
      if (prb_fire) begin
        st <= p_nxt;
        if (p_nxt == LS_I) line_dirty <= 1'b0;
      end else if (mem_ack) begin
        if (ack_frees)            st <= LS_I;
        else if (st == LS_MODI)   st <= LS_DI;
      end else if (wbd_valid) begin
        if (st == LS_MODI) begin
          st <= LS_MOI;  unblk_inval <= 1'b1;
        end else if (st == LS_DI) begin
          st <= LS_I;    unblk_inval <= 1'b1;
        end
      end else if (vn_fire) begin
        if (st == LS_MOI) begin
          st <= LS_MODI; vn_ack <= 1'b1;
        end
      end else if (repl_go) begin
        st         <= st_owned ? LS_MOI : LS_ESI;
        line_dirty <= 1'b0;
      end else if (fill_go) begin
        st         <= line_st_e'(fill_st);
        line_data  <= fill_data;
        line_dirty <= fill_dirty;
      end
    end
  end

  // R12: one response per accepted probe, held under back-pressure
  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    prb_fire |=> rsp_valid);
  a_r12_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit)
                                && $stable(rsp_nsl) && $stable(rsp_dirty));
  // R3: victim held until taken
  a_r3_vic_stable: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && !vic_ready |=> vic_valid && $stable(vic_data) && $stable(vic_is_dirty));
  // R8: memory acknowledge ends an eviction
  a_r8_ack_to_inv: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && !prb_fire && ack_frees |=> (line_st == 4'd0) && !hold_full);
  // R10: cancel-wait holds off victim notices
  a_r10_ic_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_IC) |-> !vn_ready);
  // R11: malformed probe leaves the line untouched
  a_r11_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    prb_fire && dec_bad |=> err && (line_st == $past(line_st)));
endmodule

// File: tb/tb_lc_evict_ctrl.sv
`timescale 1ns/1ps
module tb_lc_evict_ctrl;
  localparam int DW = 32;
  localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_O = 3, ST_M = 4;
  localparam int ST_MOI = 5, ST_ESI = 6, ST_MODI = 7, ST_DI = 8, ST_IC = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_en = 0, fill_dirty = 0, repl_req = 0;
  logic [3:0] fill_st = '0;
  logic [DW-1:0] fill_data = '0;
  logic prb_valid = 0, prb_ret = 0, rsp_ready = 0, vic_ready = 0;
  logic [1:0] prb_kind = '0;
  logic mem_ack = 0, vn_valid = 0, wbd_valid = 0;
  logic prb_ready, rsp_valid, rsp_hit, rsp_dirty, rsp_nsl, rsp_has_data;
  logic [DW-1:0] rsp_data, vic_data;
  logic vic_valid, vic_is_dirty, vn_ready, vn_ack, unblk_inval, err;
  logic [3:0] line_st;

  int total = 0, bad = 0;
  int m_st = ST_I;
  logic [DW-1:0] m_data = '0, h_data = '0;
  logic m_dirty = 0, h_dirty = 0;

  always #2.5 clk = ~clk;

  lc_evict_ctrl #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_st(fill_st),
    .fill_data(fill_data), .fill_dirty(fill_dirty), .repl_req(repl_req),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind),
    .prb_ret(prb_ret), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .rsp_nsl(rsp_nsl),
    .rsp_has_data(rsp_has_data), .rsp_data(rsp_data), .vic_valid(vic_valid),
    .vic_ready(vic_ready), .vic_is_dirty(vic_is_dirty), .vic_data(vic_data),
    .mem_ack(mem_ack), .vn_valid(vn_valid), .vn_ready(vn_ready),
    .vn_ack(vn_ack), .wbd_valid(wbd_valid), .unblk_inval(unblk_inval),
    .err(err), .line_st(line_st)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic void model_probe(input int st, input int kind, input bit ret,
      output bit hit, output bit nsl, output bit hasd, output bit dty,
      output logic [DW-1:0] data, output int nst, output bit e);
    bit inv;
    hit = 0; nsl = 0; hasd = 0; dty = 0; data = '0; nst = st;
    e = (kind == 1 && !ret) || kind >= 2;
    inv = (kind == 0);
    if (e) return;
    if (st >= ST_S && st <= ST_M) begin
      if (inv && ret) begin hit = 1; hasd = 1; data = m_data; dty = m_dirty; nst = ST_I; end
      else if (inv)   begin nsl = 1; nst = ST_I; end
      else begin hit = 1; hasd = 1; data = m_data; dty = m_dirty; nst = (st >= ST_O) ? ST_O : ST_S; end
    end else if (st == ST_MOI) begin
      if (inv && ret) begin hit = 1; hasd = 1; data = h_data; dty = h_dirty; nst = ST_IC; end
      else if (inv)   begin nsl = 1; nst = ST_IC; end
      else begin hit = 1; hasd = 1; data = h_data; dty = h_dirty; end
    end else if (st == ST_ESI) begin
      if (inv) begin nsl = 1; nst = ST_IC; end
      else begin hit = 1; hasd = 1; data = h_data; dty = h_dirty; end
    end else begin
      if (inv) nsl = 1;
    end
  endfunction

  task automatic chk_rsp(input string req, input bit hit, input bit nsl, input bit hasd,
                         input bit dty, input logic [DW-1:0] data);
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({req, " hit"}, 64'(rsp_hit), 64'(hit));
    check({req, " nsl"}, 64'(rsp_nsl), 64'(nsl));
    check({req, " has_data"}, 64'(rsp_has_data), 64'(hasd));
    check({req, " dirty"}, 64'(rsp_dirty), 64'(dty));
    check({req, " data"}, 64'(rsp_data), 64'(data));
  endtask

  task automatic drain_rsp();
    rsp_ready = 1;
    @(negedge clk) rsp_ready = 0;
    check("R12 rsp drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic do_probe(input int kind, input bit ret, input bit bp);
    bit hit, nsl, hasd, dty, e; logic [DW-1:0] d; int nst; string tag;
    model_probe(m_st, kind, ret, hit, nsl, hasd, dty, d, nst, e);
    tag = e ? "R11" : (m_st >= ST_MOI && m_st <= ST_ESI) ? "R7" :
          (m_st == ST_IC) ? "R10" : (kind == 1) ? "R6" : ret ? "R4" : "R5";
    @(negedge clk);
    check("R12 prb_ready", 64'(prb_ready), 64'd1);
    prb_valid = 1; prb_kind = 2'(kind); prb_ret = ret;
    @(negedge clk) prb_valid = 0;
    chk_rsp(tag, hit, nsl, hasd, dty, d);
    check("R11 err", 64'(err), 64'(e));
    check({tag, " state"}, 64'(line_st), 64'(nst));
    if (bp) begin
      @(negedge clk);
      chk_rsp("R12 held", hit, nsl, hasd, dty, d);
    end
    if (nst == ST_I && m_st <= ST_M) m_dirty = 0;
    m_st = nst;
    drain_rsp();
  endtask

  task automatic do_fill(input int st, input logic [DW-1:0] d, input bit dty);
    @(negedge clk) fill_en = 1; fill_st = 4'(st); fill_data = d; fill_dirty = dty;
    @(negedge clk) fill_en = 0;
    if (m_st <= ST_M && st <= ST_M) begin m_st = st; m_data = d; m_dirty = dty; end
    check("R2 fill state", 64'(line_st), 64'(m_st));
  endtask

  task automatic do_repl();
    bit go;
    go = (m_st >= ST_S && m_st <= ST_M);
    @(negedge clk) repl_req = 1;
    @(negedge clk) repl_req = 0;
    check("R3 vic_valid", 64'(vic_valid), 64'(go));
    if (go) begin
      check("R3 vic kind", 64'(vic_is_dirty), 64'(m_st >= ST_O));
      check("R3 vic data", 64'(vic_data), 64'(m_data));
      h_data = m_data; h_dirty = m_dirty; m_dirty = 0;
      m_st = (m_st >= ST_O) ? ST_MOI : ST_ESI;
      @(negedge clk);
      check("R3 vic held", 64'(vic_valid), 64'd1);
      vic_ready = 1;
      @(negedge clk) vic_ready = 0;
      check("R3 vic taken", 64'(vic_valid), 64'd0);
    end
    check("R3 state", 64'(line_st), 64'(m_st));
  endtask

  task automatic do_ack();
    @(negedge clk) mem_ack = 1;
    @(negedge clk) mem_ack = 0;
    if (m_st == ST_MOI || m_st == ST_ESI || m_st == ST_IC) m_st = ST_I;
    else if (m_st == ST_MODI) m_st = ST_DI;
    check("R8 ack state", 64'(line_st), 64'(m_st));
  endtask

  task automatic do_wbd();
    bit ub;
    ub = (m_st == ST_MODI || m_st == ST_DI);
    @(negedge clk) wbd_valid = 1;
    @(negedge clk) wbd_valid = 0;
    check("R9 unblk_inval", 64'(unblk_inval), 64'(ub));
    if (m_st == ST_MODI) m_st = ST_MOI; else if (m_st == ST_DI) m_st = ST_I;
    check("R9 wbd state", 64'(line_st), 64'(m_st));
  endtask

  task automatic do_vn();
    @(negedge clk) vn_valid = 1;
    check("R10 vn_ready", 64'(vn_ready), 64'(m_st != ST_IC));
    @(negedge clk) vn_valid = 0;
    check("R9 vn_ack", 64'(vn_ack), 64'(m_st == ST_MOI));
    if (m_st == ST_MOI) m_st = ST_MODI;
    check("R9 vn state", 64'(line_st), 64'(m_st));
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", 64'(line_st), 64'd0);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 vic_valid", 64'(vic_valid), 64'd0);
    check("R1 err", 64'(err), 64'd0);
    check("R1 pulses", 64'({vn_ack, unblk_inval}), 64'd0);

    // directed: probes on stable states
    do_probe(0, 1, 0);                    // R4 on I
    do_probe(1, 1, 0);                    // R6 miss on I
    do_fill(ST_M, 32'hCAFE_0001, 1);
    do_probe(1, 1, 1);                    // R6 M -> O
    do_fill(ST_E, 32'h1111_2222, 0);
    do_probe(1, 1, 0);                    // R6 E -> S
    do_probe(0, 0, 0);                    // R5 S -> I
    do_fill(ST_O, 32'hABCD_0000, 1);
    do_probe(0, 1, 0);                    // R4 O -> I with data
    // eviction with racing notice and late data (R9)
    do_fill(ST_O, 32'h0BAD_F00D, 1);
    do_repl();                            // R3 dirty victim
    do_repl();                            // R3 ignored in state 5
    do_probe(1, 1, 1);                    // R7 downgrade from hold
    do_vn();
    do_wbd();
    do_vn();
    do_ack();
    do_wbd();
    // clean eviction then cancel-wait (R7, R10)
    do_fill(ST_E, 32'h5555_AAAA, 0);
    do_repl();
    do_probe(0, 1, 0);
    do_vn();
    do_probe(1, 1, 0);
    do_probe(0, 0, 0);
    do_fill(ST_M, 32'h7777_7777, 1);      // R2 ignored in state 9
    do_ack();
    // malformed probes (R11)
    do_fill(ST_S, 32'h0000_0042, 0);
    do_probe(1, 0, 0);
    do_probe(2, 1, 0);
    do_probe(3, 0, 0);
    do_fill(ST_M, 32'h9, 0);
    // R13: probe and memory acknowledge collide in state 5
    do_fill(ST_M, 32'hDEAD_BEEF, 1);
    do_repl();
    @(negedge clk) prb_valid = 1; prb_kind = 2'b00; prb_ret = 1; mem_ack = 1;
    @(negedge clk) prb_valid = 0; mem_ack = 0;
    chk_rsp("R13 probe first", 1, 0, 1, 1, 32'hDEAD_BEEF);
    check("R13 state", 64'(line_st), 64'(ST_IC));
    m_st = ST_IC;
    drain_rsp();
    do_ack();

    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom % 7);
      case (sel)
        0: do_fill(int'($urandom % 6), $urandom, 1'($urandom));
        1: do_repl();
        2, 3: do_probe(int'($urandom % 4), 1'($urandom), 1'($urandom));
        4: do_ack();
        5: do_wbd();
        default: do_vn();
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule